// File: doc/BRIEF.md
# Phase-Aware Data FIFO with DMA Request Generation

This block is the byte-wide data buffer that sits between a parallel SCSI bus controller's protocol logic and the host's DMA engine. It holds up to `DEPTH` bytes and produces a DMA request line. That request line follows the direction of the current bus phase. It also follows whether DMA mode is enabled and how many bytes are free or occupied. The host can reach the buffer in two ways: through a CPU register port that offers push and pop, and through a pseudo-DMA write path. The pseudo-DMA path also steps a transfer counter down.

The request line is registered. It is re-decided on the clock edge that carries a push strobe, a pop strobe or a write of the phase field. On all other cycles it keeps its value. A pseudo-DMA write always tries to push. The transfer counter drops by one only when it is nonzero and the request line was high in the cycle of the write.

Top module: `scsi_fifo_drq`

## Requirements
- R1: After reset the FIFO is empty, `drq_o`, `overrun_o`, `tc_o`, `cpu_rdata_o` and `phase_o` are all zero.
- R2: Phase codes are 0 data out, 1 data in, 2 command, 3 status, 6 message out and 7 message in. Codes 4 and 5 are reserved. While the effective phase is reserved, an evaluating event leaves `drq_o` unchanged.
- R3: With DMA enabled in phases 0, 2 or 6 (toward the device), an evaluating event sets `drq_o` to 1 exactly when at least 2 entries are free after the event.
- R4: With DMA enabled in phases 1, 3 or 7 (toward the host), an evaluating event sets `drq_o` to 1 exactly when at least 2 entries are occupied after the event.
- R5: With DMA disabled, any evaluating event in a non-reserved phase drives `drq_o` to 0.
- R6: A pseudo-DMA write into a full FIFO is dropped and sets `overrun_o`. `overrun_o` stays set until `ovr_clr_i` is pulsed.
- R7: A CPU push into a full FIFO is ignored. Contents and level are unchanged and `overrun_o` is not set.
- R8: A pop from an empty FIFO returns 0 on `cpu_rdata_o` and leaves the level at 0.
- R9: A pseudo-DMA write decrements `tc_o` by one only if `tc_o` is nonzero and `drq_o` was 1 in that cycle. `tc_load_i` loads `tc_load_val_i` and takes priority over the decrement.
- R10: A write of the phase field updates `phase_o` and re-decides `drq_o` on the same clock edge, using the new phase.
- R11: Bytes leave in the order they entered. A popped byte appears on `cpu_rdata_o` one clock after the pop strobe and is held until the next pop.
- R12: On a cycle with no push, pop or phase write, `drq_o` holds, even if `dma_en_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dma_en_i | input | 1 | DMA mode enabled |
| phase_we_i | input | 1 | Write strobe for the phase field |
| phase_i | input | 3 | New bus phase code |
| cpu_push_i | input | 1 | CPU port push strobe |
| cpu_wdata_i | input | 8 | CPU push data |
| cpu_pop_i | input | 1 | CPU port pop strobe |
| cpu_rdata_o | output | 8 | Last popped byte (0 if popped while empty) |
| pdma_push_i | input | 1 | Pseudo-DMA write strobe |
| pdma_wdata_i | input | 8 | Pseudo-DMA write data |
| tc_load_i | input | 1 | Transfer counter load strobe |
| tc_load_val_i | input | 16 | Transfer counter load value |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| phase_o | output | 3 | Current bus phase code |
| drq_o | output | 1 | DMA request |
| level_o | output | 5 | Occupied entries |
| tc_o | output | 16 | Transfer counter |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is the pair of request thresholds near the ends of the buffer. The request line should fall at 15 entries in a to-device phase and stay low below 2 entries in a to-host phase. The bench pushes and pops one byte at a time and compares against a reference queue at every level. A second hard case is a pseudo-DMA write issued after DMA mode has been dropped without an intervening event. There, the counter still decrements once on the stale high request and then freezes. The bench reaches this by loading the counter, clearing `dma_en_i` on an idle cycle, and then writing twice.

// File: rtl/scsi_fifo_pkg.sv
package scsi_fifo_pkg;
  typedef enum logic [2:0] {
    PH_DOUT = 3'd0,
    PH_DIN  = 3'd1,
    PH_CMD  = 3'd2,
    PH_STAT = 3'd3,
    PH_RSV4 = 3'd4,
    PH_RSV5 = 3'd5,
    PH_MOUT = 3'd6,
    PH_MIN  = 3'd7
  } bus_phase_e;

  typedef enum logic [1:0] {
    DIR_TO_DEV,
    DIR_TO_HOST,
    DIR_NONE
  } xfer_dir_e;

  function automatic xfer_dir_e phase_dir(bus_phase_e p);
    case (p)
      PH_DOUT, PH_CMD, PH_MOUT: return DIR_TO_DEV;
      PH_DIN, PH_STAT, PH_MIN:  return DIR_TO_HOST;
      default:                  return DIR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic [CNT_W-1:0]  used_o,
  output logic [CNT_W-1:0]  used_nx_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == DEPTH_C);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (cnt_q != '0);

  always_comb begin
    used_nx_o = cnt_q;
    case ({do_push, do_pop})
      2'b10:   used_nx_o = cnt_q + 1'b1;
      2'b01:   used_nx_o = cnt_q - 1'b1;
      default: used_nx_o = cnt_q;
    endcase
  end
  assign used_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rdata_o  <= '0;
    end else begin
      cnt_q <= used_nx_o;
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_C) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_C) ? '0 : rd_ptr_q + 1'b1;
      if (pop_i)   rdata_o  <= do_pop ? mem_q[rd_ptr_q] : '0;
    end
  end

  assert_full_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (used_o == DEPTH_C));
  assert_empty_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_o == '0 && pop_i) |=> (rdata_o == '0));
  assert_level_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= DEPTH_C);
endmodule

// File: rtl/scsi_drq_gen.sv
module scsi_drq_gen
  import scsi_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  bus_phase_e       phase_i,
  input  logic             dma_en_i,
  input  logic [CNT_W-1:0] used_nx_i,
  output logic             drq_o
);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(THRESH);

  logic [CNT_W-1:0] free_nx;
  logic             drq_d;
  xfer_dir_e        dir;

  assign free_nx = DEPTH_C - used_nx_i;
  assign dir     = phase_dir(phase_i);

  always_comb begin
    drq_d = drq_o;
    if (eval_i) begin
      case (dir)
        DIR_TO_DEV:  drq_d = dma_en_i && (free_nx >= THRESH_C);
        DIR_TO_HOST: drq_d = dma_en_i && (used_nx_i >= THRESH_C);
        default:     drq_d = drq_o;  // reserved phase: no re-evaluation
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drq_o <= 1'b0;
    else         drq_o <= drq_d;
  end

  assert_dma_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !dma_en_i && dir != DIR_NONE) |=> !drq_o);
  assert_rsv_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && dir == DIR_NONE) |=> $stable(drq_o));
  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(drq_o));
endmodule

// File: rtl/scsi_xfer_counter.sv
module scsi_xfer_counter #(
  parameter int TC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [TC_W-1:0] load_val_i,
  input  logic            dec_req_i,
  input  logic            drq_i,
  output logic [TC_W-1:0] tc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             tc_o <= '0;
    else if (load_i)                         tc_o <= load_val_i;
    else if (dec_req_i && drq_i && tc_o != '0) tc_o <= tc_o - 1'b1;
  end

  assert_tc_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_req_i && !load_i && !drq_i) |=> $stable(tc_o));
  assert_tc_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o == '0 && !load_i) |=> (tc_o == '0));
endmodule

// File: rtl/scsi_fifo_drq.sv
module scsi_fifo_drq
  import scsi_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int TC_W   = 16,
  parameter int THRESH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              phase_we_i,
  input  logic [2:0]        phase_i,
  input  logic              cpu_push_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_pop_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              pdma_push_i,
  input  logic [DATA_W-1:0] pdma_wdata_i,
  input  logic              tc_load_i,
  input  logic [TC_W-1:0]   tc_load_val_i,
  input  logic              ovr_clr_i,
  output logic [2:0]        phase_o,
  output logic              drq_o,
  output logic [CNT_W-1:0]  level_o,
  output logic [TC_W-1:0]   tc_o,
  output logic              overrun_o
);
  bus_phase_e        phase_q, phase_nx;
  logic              fifo_full, fifo_push, eval;
  logic [DATA_W-1:0] push_data;
  logic [CNT_W-1:0]  used_nx;

  assign phase_nx  = phase_we_i ? bus_phase_e'(phase_i) : phase_q;
  assign fifo_push = pdma_push_i || cpu_push_i;
  assign push_data = pdma_push_i ? pdma_wdata_i : cpu_wdata_i;
  assign eval      = fifo_push || cpu_pop_i || phase_we_i;
  assign phase_o   = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_DOUT;
      overrun_o <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      // only the pseudo-DMA path reports a dropped byte
      if (pdma_push_i && fifo_full) overrun_o <= 1'b1;
      else if (ovr_clr_i)           overrun_o <= 1'b0;
    end
  end

  scsi_byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i   (fifo_push),
    .wdata_i  (push_data),
    .pop_i    (cpu_pop_i),
    .full_o   (fifo_full),
    .used_o   (level_o),
    .used_nx_o(used_nx),
    .rdata_o  (cpu_rdata_o)
  );

  scsi_drq_gen #(.DEPTH(DEPTH), .THRESH(THRESH)) u_drq (
    .clk_i, .rst_ni,
    .eval_i   (eval),
    .phase_i  (phase_nx),
    .dma_en_i (dma_en_i),
    .used_nx_i(used_nx),
    .drq_o    (drq_o)
  );

  scsi_xfer_counter #(.TC_W(TC_W)) u_tc (
    .clk_i, .rst_ni,
    .load_i    (tc_load_i),
    .load_val_i(tc_load_val_i),
    .dec_req_i (pdma_push_i),
    .drq_i     (drq_o),
    .tc_o      (tc_o)
  );

  assert_ovr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);
  assert_cpu_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full && cpu_push_i && !pdma_push_i && !ovr_clr_i) |=> $stable(overrun_o));
  assert_phase_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_we_i |=> (phase_o == $past(phase_i)));
endmodule

// File: tb/scsi_fifo_drq_bench.sv
module scsi_fifo_drq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        dma_en = 0, phase_we = 0, cpu_push = 0, cpu_pop = 0, pdma_push = 0;
  logic        tc_load = 0, ovr_clr = 0;
  logic [2:0]  phase_in = 0;
  logic [7:0]  cpu_wdata = 0, pdma_wdata = 0, rdata;
  logic [15:0] tc_val = 0, tc;
  logic [2:0]  phase_out;
  logic        drq, ovr;
  logic [4:0]  level;

  int checks = 0, errors = 0;

  byte unsigned mq[$];
  bit          m_drq = 0, m_ovr = 0, m_dma = 0;
  int          m_tc = 0;
  logic [2:0]  m_ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_fifo_drq u_scsi_fifo_drq (
    .clk_i(clk), .rst_ni(rst_ni), .dma_en_i(dma_en),
    .phase_we_i(phase_we), .phase_i(phase_in),
    .cpu_push_i(cpu_push), .cpu_wdata_i(cpu_wdata),
    .cpu_pop_i(cpu_pop), .cpu_rdata_o(rdata),
    .pdma_push_i(pdma_push), .pdma_wdata_i(pdma_wdata),
    .tc_load_i(tc_load), .tc_load_val_i(tc_val), .ovr_clr_i(ovr_clr),
    .phase_o(phase_out), .drq_o(drq), .level_o(level), .tc_o(tc), .overrun_o(ovr)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit eval_drq(logic [2:0] ph, bit dma, int used, bit cur);
    case (ph)
      3'd0, 3'd2, 3'd6: return dma && ((DEPTH - used) >= 2);
      3'd1, 3'd3, 3'd7: return dma && (used >= 2);
      default:          return cur;
    endcase
  endfunction

  task automatic check_all(string req);
    chk(req, "drq", drq, m_drq);
    chk(req, "level", level, mq.size());
    chk(req, "overrun", ovr, m_ovr);
    chk(req, "tc", tc, m_tc);
    chk(req, "phase", phase_out, m_ph);
  endtask

  // one clocked operation; model updated from the requirements
  task automatic op(string req, bit cp, bit pp, bit pop, bit pw, logic [2:0] ph, byte unsigned d);
    bit old_drq = m_drq;
    bit full = (mq.size() == DEPTH);
    int rd = 0;
    @(negedge clk);
    cpu_push = cp; pdma_push = pp; cpu_pop = pop; phase_we = pw; phase_in = ph;
    cpu_wdata = d; pdma_wdata = d;
    if (pop) rd = (mq.size() != 0) ? int'(mq.pop_front()) : 0;
    if (pp) begin
      if (!full) mq.push_back(d); else m_ovr = 1;
      if (m_tc != 0 && old_drq) m_tc--;
    end else if (cp && !full) mq.push_back(d);
    if (pw) m_ph = ph;
    if (cp || pp || pop || pw) m_drq = eval_drq(m_ph, m_dma, mq.size(), m_drq);
    @(negedge clk);
    cpu_push = 0; pdma_push = 0; cpu_pop = 0; phase_we = 0;
    check_all(req);
    if (pop) chk(req, "rdata", rdata, rd);
  endtask

  task automatic set_dma(bit v);
    @(negedge clk); dma_en = v; m_dma = v;
  endtask

  task automatic load_tc(int v);
    @(negedge clk); tc_load = 1; tc_val = 16'(v); m_tc = v;
    @(negedge clk); tc_load = 0;
    chk("R9", "tc load", tc, m_tc);
  endtask

  task automatic drain(string req);
    while (mq.size() != 0) op(req, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_reset();
    check_all("R1");
    chk("R1", "rdata", rdata, 0);
  endtask

  task automatic t_to_device();
    set_dma(1);
    op("R10", 0, 0, 0, 1, 3'd0, 0);          // empty, 16 free -> high
    for (int i = 0; i < DEPTH; i++) op("R3", 1, 0, 0, 0, 0, byte'(8'h30 + i));
    op("R3", 0, 0, 1, 0, 0, 0);              // 15 used, 1 free -> low
    op("R3", 0, 0, 1, 0, 0, 0);              // 14 used -> high
    drain("R11");
  endtask

  task automatic t_to_host();
    op("R10", 0, 0, 0, 1, 3'd1, 0);          // to-host, empty -> low
    op("R4", 1, 0, 0, 0, 0, 8'hA1);
    op("R4", 1, 0, 0, 0, 0, 8'hA2);          // 2 used -> high
    op("R4", 0, 0, 1, 0, 0, 0);              // 1 used -> low
    op("R10", 0, 0, 0, 1, 3'd7, 0);
    op("R4", 1, 0, 0, 0, 0, 8'hA3);
    drain("R11");
    op("R10", 0, 0, 0, 1, 3'd2, 0);          // command, empty -> high
  endtask

  task automatic t_reserved();
    op("R2", 0, 0, 0, 1, 3'd4, 0);           // stays high
    op("R2", 1, 0, 0, 0, 0, 8'h11);
    op("R2", 0, 0, 0, 1, 3'd5, 0);
    op("R2", 0, 0, 1, 0, 0, 0);
    op("R2", 0, 0, 0, 1, 3'd3, 0);           // status, empty -> low
    op("R2", 0, 0, 0, 1, 3'd4, 0);           // reserved holds low
    for (int i = 0; i < 3; i++) op("R2", 1, 0, 0, 0, 0, byte'(i));
    drain("R2");
  endtask

  task automatic t_dma_off();
    op("R10", 0, 0, 0, 1, 3'd6, 0);          // message out, high
    set_dma(0);
    @(negedge clk); check_all("R12");        // no event: holds
    op("R5", 1, 0, 0, 0, 0, 8'h55);
    set_dma(1);
    @(negedge clk); check_all("R12");
    op("R5", 0, 0, 1, 0, 0, 0);              // event with dma on -> high
  endtask

  task automatic t_overrun();
    op("R10", 0, 0, 0, 1, 3'd0, 0);
    for (int i = 0; i < DEPTH; i++) op("R6", 1, 0, 0, 0, 0, byte'(8'hC0 + i));
    op("R7", 1, 0, 0, 0, 0, 8'hEE);          // ignored, no overrun
    op("R6", 0, 1, 0, 0, 0, 8'hEF);          // dropped, overrun
    @(negedge clk); @(negedge clk); check_all("R6");
    @(negedge clk); ovr_clr = 1; m_ovr = 0;
    @(negedge clk); ovr_clr = 0; check_all("R6");
    drain("R7");
  endtask

  task automatic t_empty_pop();
    op("R8", 0, 0, 1, 0, 0, 0);
    op("R8", 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_counter();
    load_tc(3);
    for (int i = 0; i < 4; i++) op("R9", 0, 1, 0, 0, 0, byte'(8'h70 + i));
    load_tc(5);
    set_dma(0);
    op("R9", 0, 1, 0, 0, 0, 8'h80);          // stale high drq: 5 -> 4, drq low
    op("R9", 0, 1, 0, 0, 0, 8'h81);          // drq low: stays 4
    drain("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_to_device();
    t_to_host();
    t_reserved();
    t_dma_off();
    t_overrun();
    t_empty_pop();
    t_counter();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule